// File: doc/BRIEF.md
# Parallel Peripheral Register Bus Slave

This block sits between a host controller and a small group of internal peripherals: a card UART, a clock generator, a power sequencer and a window onto an auxiliary RAM. The host reaches them over an 8-bit bidirectional data bus, a 4-bit register address, a read/write select and an active-low enable strobe. The strobe frames each access and has no timing relationship to the block clock. The block decodes the address, turns a write into one register update, puts the addressed register onto the data bus during a read, and merges its interrupt sources into one active-low request line.

The strobe, the select and the address each pass through a two-flop synchroniser. An access starts on the falling edge of the synchronised strobe. A write captures the bus value once at that edge. A read loads the addressed register into an output holding register, and the bus is driven only while the raw strobe stays low. There are two interrupt sources: a change of the card-present level and a receive event from the UART. Each one sets a sticky pending bit. Reading the status register clears the pending bits. A source that is still active at that moment sets its bit again at once, so the request line stays low.

Top module: `pbus_slave`

## Requirements
- R1: Read/write select high means read, low means write. The read/write registers are UART data (0x0), UART control (0x1), interrupt enable (0x3), clock configuration (0x4), sequencer control (0x5) and RAM pointer (0x6). A value written to any of them reads back unchanged.
- R2: During a read, the addressed register value is on the data bus no later than four clock edges after the enable strobe falls, and it stays there while the strobe is low.
- R3: When the enable strobe returns high, the block releases the data bus at once, so another driver can use it without contention.
- R4: A write commits exactly once, with the bus value present when the synchronised strobe falls. A change of the bus while the strobe is still low has no effect.
- R5: Addresses 0x8 to 0xF read back as 0x00. Writes to them change no register.
- R6: Reading the status register (0x2) clears every pending bit. The interrupt line then returns high if no source is still active.
- R7: A change of the card-present level, in either direction, sets pending bit 1 of the status register. The interrupt line goes low only if interrupt-enable bit 0 is set.
- R8: A receive event sets pending bit 2 of the status register, gated by interrupt-enable bit 1. While the event input stays high, a status read does not release the interrupt line.
- R9: The auxiliary RAM data register (0x7) reads and writes the RAM word that the pointer register (0x6) selects. Different words hold their values independently.
- R10: The status register is read-only. Bit 0 is the synchronised card-present level, bit 1 is card-change pending, bit 2 is receive pending, and bits 7:3 read 0.
- R11: After reset, every register reads 0x00, the interrupt line is high and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Active-low access strobe from the host, asynchronous |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 4 | Register address |
| bus_data | inout | 8 | Bidirectional data bus |
| card_sense | input | 1 | Card-present level, asynchronous |
| rx_event | input | 1 | UART receive event, asynchronous, active high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Counting from the host lowering the strobe, read data lands in the holding register on the third rising edge (two synchroniser flops plus the capture flop). A write commits on that same edge. The bench therefore samples the bus on the falling clock edge after the fourth rising edge, one clock later than needed. An interrupt source lowers the request line on the fourth edge after it changes, and a status read raises the line one edge after the clear. So the bench waits six cycles before checking the interrupt line, and checks the line after the read strobe has been released. Bus release is combinational from the raw strobe, so the bench drives its own value in the same instant it raises the strobe and reads it back one nanosecond later.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int NUM_SRC = 2;
    localparam int NUM_GEN = 6;

    localparam int SRC_CARD = 0;
    localparam int SRC_RX = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_UDATA  = 4'h0,
        RA_UCTRL  = 4'h1,
        RA_STATUS = 4'h2,
        RA_IEN    = 4'h3,
        RA_CLKCFG = 4'h4,
        RA_SEQ    = 4'h5,
        RA_RPTR   = 4'h6,
        RA_RDATA  = 4'h7
    } reg_addr_e;

    // index of a general read/write register, or -1 when not one
    function automatic int gen_index(input logic [ADDR_W-1:0] a);
        case (a)
            RA_UDATA:  return 0;
            RA_UCTRL:  return 1;
            RA_IEN:    return 2;
            RA_CLKCFG: return 3;
            RA_SEQ:    return 4;
            RA_RPTR:   return 5;
            default:   return -1;
        endcase
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/pbus_regbank.sv
module pbus_regbank
    import pbus_pkg::*;
#(
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_val,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_SRC-1:0] ien
);

    localparam int PTR_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    typedef struct {
        logic [DATA_W-1:0] gen [NUM_GEN];
        logic [DATA_W-1:0] ram [RAM_DEPTH];
    } bank_t;

    bank_t st_d, st_q;
    logic [PTR_W-1:0] ptr;
    int widx;

    assign ptr  = st_q.gen[5][PTR_W-1:0];
    assign widx = gen_index(addr);

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            if (widx >= 0) begin
                st_d.gen[widx] = wdata;
            end else if (addr == RA_RDATA) begin
                st_d.ram[ptr] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GEN; i++) st_q.gen[i] <= '0;
            for (int j = 0; j < RAM_DEPTH; j++) st_q.ram[j] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (widx >= 0) begin
            rdata = st_q.gen[widx];
        end else if (addr == RA_STATUS) begin
            rdata = status_val;
        end else if (addr == RA_RDATA) begin
            rdata = st_q.ram[ptr];
        end else begin
            rdata = '0;
        end
    end

    assign ien = st_q.gen[2][NUM_SRC-1:0];

    // flattened view for the checks below
    logic [NUM_GEN*DATA_W-1:0] gen_cat;
    always_comb begin
        for (int k = 0; k < NUM_GEN; k++) gen_cat[k*DATA_W +: DATA_W] = st_q.gen[k];
    end

    assert_unmapped_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr[ADDR_W-1]) |=> $stable(gen_cat));

    assert_ctrl_roundtrip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == RA_UCTRL) |=> (st_q.gen[1] == $past(wdata)));

    assert_status_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == RA_STATUS) |=> $stable(gen_cat));

endmodule

// File: rtl/pbus_irq.sv
module pbus_irq
    import pbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_s,
    input  logic               rx_s,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] ien,
    output logic [NUM_SRC-1:0] pend,
    output logic               irq_n
);

    typedef struct packed {
        logic               card_prev;
        logic [NUM_SRC-1:0] pend;
        logic               irq_n;
    } irq_t;

    irq_t st_d, st_q;
    logic [NUM_SRC-1:0] set;

    always_comb begin
        set           = '0;
        set[SRC_CARD] = card_s ^ st_q.card_prev;
        set[SRC_RX]   = rx_s;

        st_d           = st_q;
        st_d.card_prev = card_s;
        st_d.pend      = (st_q.pend & ~{NUM_SRC{clr}}) | set;
        st_d.irq_n     = ~|(st_q.pend & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.card_prev <= 1'b0;
            st_q.pend      <= '0;
            st_q.irq_n     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend  = st_q.pend;
    assign irq_n = st_q.irq_n;

    assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (pend == '0));

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rx_s) |=> pend[SRC_RX]);

    assert_card_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_s != st_q.card_prev) |=> pend[SRC_CARD]);

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    input  logic              card_sense,
    input  logic              rx_event,
    output logic              irq_n
);

    localparam int CTL_W = ADDR_W + 3;

    logic              en_s;
    logic [CTL_W-1:0]  ctl_s;
    logic              rd_s;
    logic [ADDR_W-1:0] addr_s;
    logic              card_s;
    logic              rx_s;

    pbus_sync #(.W(1), .RST_VAL(1'b1)) u_sync_en (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_en_n),
        .dout (en_s)
    );

    pbus_sync #(.W(CTL_W), .RST_VAL('0)) u_sync_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_rd, bus_addr, card_sense, rx_event}),
        .dout (ctl_s)
    );

    assign {rd_s, addr_s, card_s, rx_s} = ctl_s;

    typedef struct packed {
        logic              en_prev;
        logic              rd_active;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;
    logic fall, wr_stb, rd_stb, stat_clr;
    logic [DATA_W-1:0]  mux_data;
    logic [DATA_W-1:0]  status_val;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ien;

    assign fall     = st_q.en_prev & ~en_s;
    assign wr_stb   = fall & ~rd_s;
    assign rd_stb   = fall & rd_s;
    assign stat_clr = rd_stb & (addr_s == RA_STATUS);

    assign status_val = {{(DATA_W-NUM_SRC-1){1'b0}}, pend, card_s};

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_s;
        if (rd_stb) begin
            st_d.rd_active = 1'b1;
            st_d.rdata     = mux_data;
        end else if (en_s) begin
            st_d.rd_active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en_prev   <= 1'b1;
            st_q.rd_active <= 1'b0;
            st_q.rdata     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pbus_regbank #(.RAM_DEPTH(RAM_DEPTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .addr      (addr_s),
        .wdata     (bus_data),
        .status_val(status_val),
        .rdata     (mux_data),
        .ien       (ien)
    );

    pbus_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .card_s(card_s),
        .rx_s  (rx_s),
        .clr   (stat_clr),
        .ien   (ien),
        .pend  (pend),
        .irq_n (irq_n)
    );

    assign bus_data = (st_q.rd_active && !bus_en_n) ? st_q.rdata : {DATA_W{1'bz}};

    assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> !st_q.rd_active);

    assert_read_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (st_q.rd_active && st_q.rdata == $past(mux_data)));

endmodule

// File: tb/pbus_slave_test.sv
module pbus_slave_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       rd = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       card = 1'b0;
    logic       rx = 1'b0;
    logic       drv_en = 1'b0;
    logic [7:0] drv_val = 8'h00;
    wire  [7:0] bus;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    assign bus = drv_en ? drv_val : 8'hzz;

    always #4 clk = ~clk;

    pbus_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en_n  (en_n),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_data  (bus),
        .card_sense(card),
        .rx_event  (rx),
        .irq_n     (irq_n)
    );

    // {address, write value, expected read value}
    localparam logic [19:0] VEC [8] = '{
        {4'h0, 8'hA5, 8'hA5},
        {4'h1, 8'h3C, 8'h3C},
        {4'h4, 8'hF0, 8'hF0},
        {4'h5, 8'h0F, 8'h0F},
        {4'h6, 8'h02, 8'h02},
        {4'h3, 8'h00, 8'h00},
        {4'hC, 8'h5A, 8'h00},
        {4'hF, 8'hFF, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b0; drv_val = d; drv_en = 1'b1;
        @(negedge clk);
        en_n = 1'b0;
        repeat (4) @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
        drv_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        drv_en = 1'b0; addr = a; rd = 1'b1;
        @(negedge clk);
        en_n = 1'b0;
        repeat (4) @(negedge clk);
        d = bus;
        en_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 irq", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(4'h1, v); check("R11 uctrl", v, 8'h00);
        bus_read(4'h2, v); check("R11 status", v, 8'h00);

        // R1 R5 vector table: write all, then read all
        for (int i = 0; i < 8; i++) bus_write(VEC[i][19:16], VEC[i][15:8]);
        for (int i = 0; i < 8; i++) begin
            bus_read(VEC[i][19:16], v);
            check("R1/R5 table", v, VEC[i][7:0]);
        end

        // R5 unmapped write left mapped registers untouched
        bus_write(4'h9, 8'h77);
        bus_read(4'h0, v); check("R5 alias", v, 8'hA5);
        bus_read(4'h9, v); check("R5 unmapped read", v, 8'h00);

        // R2 data on bus while strobe low, R3 release at strobe high
        @(negedge clk);
        addr = 4'h4; rd = 1'b1;
        @(negedge clk);
        en_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 early", bus, 8'hF0);
        repeat (3) @(negedge clk);
        check("R2 held", bus, 8'hF0);
        en_n = 1'b1; drv_val = 8'h81; drv_en = 1'b1;
        #1;
        check("R3 release", bus, 8'h81);
        @(negedge clk);
        drv_en = 1'b0;
        repeat (3) @(negedge clk);

        // R4 single commit: bus change while strobe low is ignored
        @(negedge clk);
        addr = 4'h5; rd = 1'b0; drv_val = 8'h11; drv_en = 1'b1;
        @(negedge clk);
        en_n = 1'b0;
        repeat (4) @(negedge clk);
        drv_val = 8'h22;
        repeat (4) @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
        drv_en = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(4'h5, v); check("R4 once", v, 8'h11);

        // R10 status is read-only
        bus_write(4'h2, 8'hFF);
        bus_read(4'h2, v); check("R10 readonly", v, 8'h00);

        // R9 auxiliary RAM
        bus_write(4'h6, 8'h03); bus_write(4'h7, 8'hC3);
        bus_write(4'h6, 8'h0A); bus_write(4'h7, 8'h5C);
        bus_read(4'h7, v); check("R9 word A", v, 8'h5C);
        bus_write(4'h6, 8'h03);
        bus_read(4'h7, v); check("R9 word 3", v, 8'hC3);

        // R7 card toggle with enable cleared: pending visible, irq stays high
        card = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 masked irq", {7'd0, irq_n}, 8'h01);
        bus_read(4'h2, v); check("R10/R7 status", v, 8'h03);
        bus_read(4'h2, v); check("R6 cleared", v, 8'h01);

        // R7 enabled card toggle (falling level)
        bus_write(4'h3, 8'h03);
        card = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 irq low", {7'd0, irq_n}, 8'h00);
        bus_read(4'h2, v); check("R7 status", v, 8'h02);
        check("R6 irq released", {7'd0, irq_n}, 8'h01);

        // R8 receive event held through status read keeps irq low
        rx = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 irq low", {7'd0, irq_n}, 8'h00);
        bus_read(4'h2, v); check("R8 status", v, 8'h04);
        check("R8 irq held", {7'd0, irq_n}, 8'h00);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(4'h2, v);
        check("R6 final release", {7'd0, irq_n}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule